// File: doc/BRIEF.md
# Pseudo-Random Sequence Receive Verifier

This block checks a word-aligned parallel receive stream that carries a seven-stage pseudo-random bit sequence (polynomial x^7 + x^6 + 1). It is meant for transceiver self-test with the transmit side looped back to the receiver. The checker stays idle until the upstream word boundary is reported as restored. It then loads its own predictor from the received bits and compares every later word against the prediction. Two status outputs result: a completion flag and an error flag. The completion flag latches once a full sequence period has been seen. The error flag is stretched and clears only after a clean period.

The word width is a parameter and may be 8 or 10 bits. Inside a word, bit 0 is the earliest bit in time. The seven-stage sequence repeats every 127 bits. Since 127 shares no factor with 8 or 10, the word stream also repeats every 127 words. A second parameter selects a fixed low-frequency pattern. That pattern has no checker, so both flags stay low when it is selected. The checker has its own synchronous active-high receive reset. Any transmit-side generator is reset independently of it.

Top module: `prbs_rx_verifier`

## Requirements
- R1: No word is accepted while `rx_aligned` is low: the checker stays in its seek state and neither flag can rise.
- R2: The first word with `rx_valid` and `rx_aligned` high whose last seven bits are not all zero loads the predictor. `chk_done` rises on the clock edge that takes the 127th later tracked word. The serial sequence obeys b[n] = b[n-7] xor b[n-6], and word bit 0 is first in time.
- R3: Once high, `chk_done` stays high whatever the data, until `rx_rst` is applied.
- R4: A mismatch sets `chk_err` only when `chk_done` is already high. Mismatches seen before that are ignored.
- R5: `chk_err` rises on the clock edge that takes a mismatching word and stays high for at least three cycles.
- R6: `chk_err` falls on the edge that takes the 127th consecutive matching tracked word after the last mismatch, and at no other time.
- R7: Words with `rx_valid` low do not advance the predictor, the period count or the clear window.
- R8: With the low-frequency pattern selected (`PATTERN` = 1), `chk_done` and `chk_err` stay low for any input.
- R9: A candidate seed whose last seven bits are all zero is rejected, and the checker keeps waiting for a usable seed.
- R10: `WORD_W` of 8 and of 10 both reach `chk_done` after the same 127-word period.
- R11: A restart of the transmit generator leaves the checker state in place. Once done, the jump in the sequence is reported through `chk_err`.
- R12: While `rx_rst` is high at a clock edge, both flags clear and the checker returns to seek.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rx_rst | input | 1 | Synchronous active-high receive reset |
| rx_word | input | WORD_W | Aligned parallel data word, bit 0 earliest |
| rx_valid | input | 1 | Word on `rx_word` is meaningful this cycle |
| rx_aligned | input | 1 | Upstream word boundary has been restored |
| chk_done | output | 1 | Latched: a full period has been tracked |
| chk_err | output | 1 | Stretched mismatch indication |

## Verification
The bench builds three instances. One uses 8-bit words with the pseudo-random pattern, one uses 10-bit words with the same pattern, and one uses 10-bit words with the low-frequency pattern selected. The first two share all control stimulus, so the period boundary is shown to land on the same word count for both widths. Only the 8-bit path receives corrupted bits, so its clean twin shows that error stretching stays local to the instance that saw the bad data. The low-frequency instance is fed its own fixed pattern throughout, which covers the quiet-flag variant.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int unsigned LFSR_LEN     = 7;
    localparam int unsigned MAX_W        = 10;
    localparam int unsigned PERIOD_WORDS = (1 << LFSR_LEN) - 1;

    typedef enum logic {
        PAT_PRBS7   = 1'b0,
        PAT_LOWFREQ = 1'b1
    } pat_sel_e;

    typedef enum logic {
        ST_SEEK  = 1'b0,
        ST_TRACK = 1'b1
    } chk_state_e;

    // hist[0] is the most recent bit, hist[6] the oldest
    typedef logic [LFSR_LEN-1:0] hist_t;
    typedef logic [MAX_W-1:0]    wpad_t;

    typedef struct packed {
        wpad_t bits;
        hist_t hist;
    } step_t;

    typedef struct packed {
        logic take;
        logic mism;
    } word_evt_t;

    // Predict the next nbits serial bits, earliest in bit 0
    function automatic step_t predict_word(hist_t h, int unsigned nbits);
        step_t r;
        hist_t t;
        logic  nb;
        r.bits = '0;
        t      = h;
        for (int i = 0; i < int'(MAX_W); i++) begin
            if (i < int'(nbits)) begin
                nb        = t[6] ^ t[5];
                r.bits[i] = nb;
                t         = {t[5:0], nb};
            end
        end
        r.hist = t;
        return r;
    endfunction

    // Take the last seven bits of a word as predictor history
    function automatic hist_t seed_from_word(wpad_t w, int unsigned nbits);
        hist_t h;
        h = '0;
        for (int j = 0; j < int'(LFSR_LEN); j++) begin
            h[j] = w[int'(nbits) - 1 - j];
        end
        return h;
    endfunction

endpackage

// File: rtl/prbs_seed_track.sv
module prbs_seed_track
    import prbs_chk_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_en,
    input  logic [WORD_W-1:0] word,
    input  logic              valid,
    input  logic              aligned,
    output word_evt_t         evt
);

    chk_state_e state;
    hist_t      hist;
    wpad_t      wpad;
    step_t      pred;
    hist_t      seed;
    logic       take_word;

    assign wpad      = wpad_t'(word);
    assign take_word = chk_en & valid & aligned;
    assign pred      = predict_word(hist, WORD_W);
    assign seed      = seed_from_word(wpad, WORD_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SEEK;
            hist  <= '0;
        end else if (take_word) begin
            case (state)
                ST_SEEK: begin
                    if (seed != '0) begin
                        hist  <= seed;
                        state <= ST_TRACK;
                    end
                end
                ST_TRACK: hist <= pred.hist;
                default:  state <= ST_SEEK;
            endcase
        end
    end

    always_comb begin
        evt.take = take_word && (state == ST_TRACK);
        evt.mism = evt.take && (pred.bits != wpad);
    end

    // R1: no progress out of seek without alignment
    a_r1_seek_needs_align: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEEK && !aligned) |=> (state == ST_SEEK));

    // R9: an all-zero candidate seed leaves the checker seeking
    a_r9_zero_seed_rejected: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEEK && take_word && wpad == '0) |=> (state == ST_SEEK));

    // R7: predictor frozen when no word is taken
    a_r7_hist_frozen: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRACK && !take_word) |=> $stable(hist));

endmodule

// File: rtl/prbs_period_track.sv
module prbs_period_track
    import prbs_chk_pkg::*;
#(
    parameter int unsigned PER_WORDS = PERIOD_WORDS
) (
    input  logic      clk,
    input  logic      rst,
    input  word_evt_t evt,
    output logic      done
);

    localparam int unsigned CNT_W = $clog2(PER_WORDS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PER_WORDS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (evt.take && !done) begin
            if (cnt == CNT_LAST) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: completion latches until reset
    a_r3_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R2: completion only rises on a tracked word
    a_r2_done_on_take: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(evt.take));

    // R7: period count holds without a tracked word
    a_r7_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
        !evt.take |=> $stable(cnt));

endmodule

// File: rtl/prbs_err_stretch.sv
module prbs_err_stretch
    import prbs_chk_pkg::*;
#(
    parameter int unsigned PER_WORDS   = PERIOD_WORDS,
    parameter int unsigned MIN_ERR_CYC = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  word_evt_t evt,
    input  logic      done,
    output logic      err
);

    localparam int unsigned WIN_W  = $clog2(PER_WORDS);
    localparam int unsigned HOLD_W = $clog2(MIN_ERR_CYC + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(PER_WORDS - 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(MIN_ERR_CYC - 1);

    logic [WIN_W-1:0]  win;
    logic [HOLD_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            err  <= 1'b0;
            win  <= '0;
            hold <= '0;
        end else begin
            if (hold != '0) begin
                hold <= hold - 1'b1;
            end
            if (evt.take && done) begin
                if (evt.mism) begin
                    err  <= 1'b1;
                    hold <= HOLD_LOAD;
                    win  <= '0;
                end else if (err) begin
                    if (win == WIN_LAST) begin
                        if (hold == '0) begin
                            err <= 1'b0;
                        end
                    end else begin
                        win <= win + 1'b1;
                    end
                end
            end
        end
    end

    // R4: no error indication before completion
    a_r4_err_after_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R5: error held at least three cycles
    a_r5_err_min_width: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |=> err ##1 err);

    // R6: error only clears on a clean tracked word
    a_r6_clear_on_clean: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> $past(evt.take && !evt.mism));

endmodule

// File: rtl/prbs_rx_verifier.sv
module prbs_rx_verifier
    import prbs_chk_pkg::*;
#(
    parameter int unsigned WORD_W      = 8,
    parameter pat_sel_e    PATTERN     = PAT_PRBS7,
    parameter int unsigned MIN_ERR_CYC = 3
) (
    input  logic              clk,
    input  logic              rx_rst,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_valid,
    input  logic              rx_aligned,
    output logic              chk_done,
    output logic              chk_err
);

    logic      chk_en;
    word_evt_t evt;

    generate
        if (PATTERN == PAT_LOWFREQ) begin : g_no_checker
            assign chk_en = 1'b0;
        end else begin : g_prbs_checker
            assign chk_en = 1'b1;
        end
    endgenerate

    prbs_seed_track #(.WORD_W(WORD_W)) u_seed (
        .clk     (clk),
        .rst     (rx_rst),
        .chk_en  (chk_en),
        .word    (rx_word),
        .valid   (rx_valid),
        .aligned (rx_aligned),
        .evt     (evt)
    );

    prbs_period_track #(.PER_WORDS(PERIOD_WORDS)) u_period (
        .clk  (clk),
        .rst  (rx_rst),
        .evt  (evt),
        .done (chk_done)
    );

    prbs_err_stretch #(
        .PER_WORDS   (PERIOD_WORDS),
        .MIN_ERR_CYC (MIN_ERR_CYC)
    ) u_err (
        .clk  (clk),
        .rst  (rx_rst),
        .evt  (evt),
        .done (chk_done),
        .err  (chk_err)
    );

    // R12: flags low in the cycle after a reset edge
    a_r12_reset_clears: assert property (@(posedge clk)
        rx_rst |=> (!chk_done && !chk_err));

endmodule

// File: tb/prbs_tx_source.sv
module prbs_tx_source #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         tx_rst,
    input  logic         adv,
    output logic [W-1:0] word
);

    // s[0] holds the oldest bit of the last seven
    logic [6:0] s;
    logic [6:0] s_nxt;

    always_comb begin
        logic [6:0] t;
        logic       nb;
        t    = s;
        word = '0;
        for (int i = 0; i < int'(W); i++) begin
            nb      = t[0] ^ t[1];
            word[i] = nb;
            t       = {nb, t[6:1]};
        end
        s_nxt = t;
    end

    always_ff @(posedge clk) begin
        if (tx_rst)   s <= 7'b1000000;
        else if (adv) s <= s_nxt;
    end

endmodule

// File: tb/prbs_rx_verifier_tb.sv
module prbs_rx_verifier_tb;
    import prbs_chk_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rx_rst = 1'b1, tx_rst = 1'b1;
    logic valid = 1'b0, aligned = 1'b0, corrupt = 1'b0, zero_mode = 1'b0;
    logic [7:0] g8;
    logic [9:0] g10;
    logic [7:0] d8;
    logic [9:0] d10;
    logic done8, err8, done10, err10, done_lf, err_lf;
    int total = 0, bad = 0;
    bit finished = 0;

    prbs_tx_source #(.W(8))  u_gen8  (.clk(clk), .tx_rst(tx_rst), .adv(valid & ~zero_mode), .word(g8));
    prbs_tx_source #(.W(10)) u_gen10 (.clk(clk), .tx_rst(tx_rst), .adv(valid & ~zero_mode), .word(g10));

    assign d8  = zero_mode ? 8'h00  : !valid ? 8'hA5  : corrupt ? (g8 ^ 8'h01) : g8;
    assign d10 = zero_mode ? 10'h000 : !valid ? 10'h2A5 : g10;

    prbs_rx_verifier #(.WORD_W(8)) u_dut (
        .clk(clk), .rx_rst(rx_rst), .rx_word(d8), .rx_valid(valid),
        .rx_aligned(aligned), .chk_done(done8), .chk_err(err8));

    prbs_rx_verifier #(.WORD_W(10)) u_w10 (
        .clk(clk), .rx_rst(rx_rst), .rx_word(d10), .rx_valid(valid),
        .rx_aligned(aligned), .chk_done(done10), .chk_err(err10));

    prbs_rx_verifier #(.WORD_W(10), .PATTERN(PAT_LOWFREQ)) u_lf (
        .clk(clk), .rx_rst(rx_rst), .rx_word(10'b1111100000), .rx_valid(valid),
        .rx_aligned(aligned), .chk_done(done_lf), .chk_err(err_lf));

    typedef struct packed {
        logic [8:0] n;
        logic       v;
        logic       a;
        logic       c;
        logic       d;
        logic       e;
    } row_t;

    localparam row_t TBL [9] = '{
        '{9'd5,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{9'd127, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{9'd1,   1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{9'd10,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{9'd1,   1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{9'd2,   1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{9'd124, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{9'd1,   1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{9'd50,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
    };
    localparam string TAG [9] = '{"R1", "R2", "R2", "R7", "R5", "R5", "R6", "R6", "R3"};

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic words(int n, logic v, logic a, logic c, logic z);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid = v; aligned = a; corrupt = c; zero_mode = z;
        end
        @(negedge clk);
        valid = 1'b0; corrupt = 1'b0; zero_mode = 1'b0;
    endtask

    task automatic pulse_rx_rst();
        @(negedge clk); rx_rst = 1'b1;
        @(negedge clk); rx_rst = 1'b0;
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset done", done8, 1'b0);
        chk("R12 reset err", err8, 1'b0);
        rx_rst = 1'b0; tx_rst = 1'b0;

        for (int r = 0; r < 9; r++) begin
            words(int'(TBL[r].n), TBL[r].v, TBL[r].a, TBL[r].c, 1'b0);
            chk({TAG[r], " done w8"}, done8, TBL[r].d);
            chk({TAG[r], " err w8"}, err8, TBL[r].e);
            chk({"R10 done w10 ", TAG[r]}, done10, TBL[r].d);
            chk("R10 err w10 clean", err10, 1'b0);
            chk("R8 lowfreq done", done_lf, 1'b0);
            chk("R8 lowfreq err", err_lf, 1'b0);
        end

        // R12 and R3: only the receive reset drops the latched flag
        pulse_rx_rst();
        chk("R12 rx reset clears done", done8, 1'b0);
        chk("R12 rx reset clears done w10", done10, 1'b0);

        // R4: mismatches while still counting the first period are ignored
        words(1, 1'b1, 1'b1, 1'b0, 1'b0);
        words(5, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R4 early mismatch ignored", err8, 1'b0);
        chk("R4 done still low", done8, 1'b0);

        // R9: all-zero stream never seeds
        pulse_rx_rst();
        words(200, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R9 zero stream no done", done8, 1'b0);
        chk("R9 zero stream no done w10", done10, 1'b0);
        words(128, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R9 seeds after zeros", done8, 1'b1);
        chk("R10 seeds after zeros w10", done10, 1'b1);

        // R11: transmit restart keeps checker state, then shows as error
        @(negedge clk); tx_rst = 1'b1;
        @(negedge clk); tx_rst = 1'b0;
        chk("R11 done kept across tx reset", done8, 1'b1);
        chk("R11 err low before new data", err8, 1'b0);
        words(3, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R11 restart flagged", err8, 1'b1);
        chk("R11 restart flagged w10", err10, 1'b1);
        chk("R8 lowfreq final done", done_lf, 1'b0);

        wrap_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        wrap_up();
    end

endmodule